// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static memory whose data bus can switch between reads and writes on every clock with no idle cycle in between. The array holds words of four 9-bit lanes, each lane carrying eight data bits and one parity bit. Every synchronous control, address, lane enable and data input is captured on the rising clock edge. A read returns its word two active edges after its address is loaded. A write takes its data two active edges after its address and lane enables. The write is then committed to the array one active edge later. A small forwarding path covers the gap between a write's data arriving and its commit, so a read always sees the most recent write.

An access is either a fresh load, with its own address and a read/write selection, or a continuation of a four-word burst. The continuation reuses the earlier cycle type and walks through the aligned group of four either in interleaved (XOR) order or in linear (wrapping increment) order. A hold input freezes the whole pipeline for a cycle. An asynchronous output enable gates the drive of the read data. A sleep input, synchronised over two edges, parks the device with its contents retained.

Top module: `pipe_sram`

## Requirements
- R1: The device is selected on a load cycle (burst_next=0) only when en0_n=0, en1=1 and en2_n=0. A load that is not selected starts a deselected period: it writes nothing and no read data is driven for it. Continuation cycles during that period stay deselected.
- R2: A read loaded at active edge k drives its word on rdata after active edge k+2, with rdata_drive=1 while out_en_n=0.
- R3: A write loaded at active edge k samples wdata at active edge k+2. Lane i, which is bits [9i+8:9i], is written only when lane_wr_n[i]=0 in the cycle the address was taken.
- R4: A cycle with burst_next=1 continues the burst with the previous cycle type, ignoring write_n and the enables. The upper address bits stay fixed. The low two bits are start XOR count when burst_linear=0, and (start + count) mod 4 when burst_linear=1.
- R5: A write cycle with lane_wr_n=4'b1111 changes no array content, but the burst still advances.
- R6: While out_en_n=1, rdata_drive is 0 even for a completed read (a dummy read), and the burst address still advances.
- R7: With hold=1 the clock edge is ignored. No pipeline stage, burst counter or array word changes, and the data timing of pending writes slides by that edge.
- R8: The sleep input takes effect two edges after it rises and stops two edges after it falls. While it is in effect, every other synchronous input is ignored, the array is retained and rdata_drive is 0.
- R9: A read returns the latest data written to its address, including writes whose data arrived in the same or the previous active cycle. This holds under back-to-back alternation of reads and writes.
- R10: After reset the device is deselected and rdata_drive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline (array not cleared) |
| hold | input | 1 | 1 = ignore this clock edge |
| en0_n | input | 1 | Active-low enable, sampled on loads |
| en1 | input | 1 | Active-high enable, sampled on loads |
| en2_n | input | 1 | Active-low enable, sampled on loads |
| burst_next | input | 1 | 0 = load new address, 1 = continue burst |
| write_n | input | 1 | On loads: 0 = write, 1 = read |
| lane_wr_n | input | LANES | Active-low lane write enables, taken with the address |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| burst_linear | input | 1 | Static burst order: 0 interleaved, 1 linear |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous power-down request |
| rdata | output | LANES*LANE_W | Read data register |
| rdata_drive | output | 1 | 1 when rdata is actively driven, else bus released |

## Verification
The bench builds the block with its defaults: a 64-word array of four 9-bit lanes and four-word bursts. With only 64 words it can write every word during a directed fill, so every later read has a known value. The random phase draws addresses from the lowest sixteen words, which makes pending-write hits and forwarding frequent. Because all eight low-bit starting positions of both burst orders fit in the small array, wrap-around in each mode is checked against the bench's own address arithmetic.

// File: rtl/pipe_sram_pkg.sv
`timescale 1ns/1ps
package pipe_sram_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_burst_gen.sv
`timescale 1ns/1ps
module sram_burst_gen #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
    } bst_t;

    bst_t bs_d, bs_q;

    function automatic logic [ADDR_W-1:0] map_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [CNT_W-1:0] c,
                                                   input logic lin);
        logic [ADDR_W-1:0] r;
        r = b;
        if (lin) r[CNT_W-1:0] = b[CNT_W-1:0] + c;
        else     r[CNT_W-1:0] = b[CNT_W-1:0] ^ c;
        return r;
    endfunction

    always_comb begin
        bs_d   = bs_q;
        addr_o = map_addr(bs_q.base, bs_q.cnt, linear_i);
        if (load_i) begin
            addr_o = addr_i;
            if (en_i) begin
                bs_d.base = addr_i;
                bs_d.cnt  = '0;
            end
        end else if (step_i) begin
            addr_o = map_addr(bs_q.base, bs_q.cnt + 1'b1, linear_i);
            if (en_i) bs_d.cnt = bs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    AST_BURST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |-> (addr_o[ADDR_W-1:CNT_W] == bs_q.base[ADDR_W-1:CNT_W])); // R4
endmodule

// File: rtl/sram_sleep_sync.sv
`timescale 1ns/1ps
module sram_sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic asleep_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], req_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign asleep_o = sh_q[STAGES-1];
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we_i,
    input  logic [LANES-1:0]        be_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (be_i[l]) mem_q[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LANES     = 4,
    parameter int LANE_W    = 9,
    parameter int BURST_W   = 2,
    parameter int SLEEP_SYN = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    en0_n,
    input  logic                    en1,
    input  logic                    en2_n,
    input  logic                    burst_next,
    input  logic                    write_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    burst_linear,
    input  logic                    out_en_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
    } stage_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } commit_t;

    typedef struct packed {
        op_e               mode;
        stage_t            s1;
        stage_t            s2;
        commit_t           s3;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
    } state_t;

    state_t st_d, st_q;

    logic              asleep;
    logic              active;
    logic              selected;
    logic              load;
    logic              step;
    logic [ADDR_W-1:0] issue_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] fwd_data;
    logic              fwd_hit;
    logic              mem_we;

    assign active   = !hold && !asleep;
    assign selected = !en0_n && en1 && !en2_n;
    assign load     = !burst_next;
    assign step     = burst_next && (st_q.mode != OP_NONE);

    sram_sleep_sync #(
        .STAGES (SLEEP_SYN)
    ) u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (sleep),
        .asleep_o (asleep)
    );

    sram_burst_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (BURST_W)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (active),
        .load_i   (load),
        .step_i   (step),
        .linear_i (burst_linear),
        .addr_i   (addr),
        .addr_o   (issue_addr)
    );

    assign mem_we = active && st_q.s3.valid;

    sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .be_i    (st_q.s3.be),
        .waddr_i (st_q.s3.addr),
        .wdata_i (st_q.s3.data),
        .raddr_i (st_q.s2.addr),
        .rdata_o (mem_rdata)
    );

    // forward the write that is committing while the read looks at the array
    assign fwd_hit = st_q.s3.valid && (st_q.s3.addr == st_q.s2.addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fwd_data[l*LANE_W +: LANE_W] = (fwd_hit && st_q.s3.be[l])
                                            ? st_q.s3.data[l*LANE_W +: LANE_W]
                                            : mem_rdata[l*LANE_W +: LANE_W];
    end

    always_comb begin
        st_d = st_q;
        if (active) begin
            // issue stage
            if (load) begin
                if (selected) st_d.mode = write_n ? OP_READ : OP_WRITE;
                else          st_d.mode = OP_NONE;
            end
            st_d.s1.op   = st_d.mode;
            st_d.s1.addr = issue_addr;
            st_d.s1.be   = ~lane_wr_n;
            // address/enable delay toward data arrival
            st_d.s2 = st_q.s1;
            // data arrival for writes
            st_d.s3.valid = (st_q.s2.op == OP_WRITE) && (|st_q.s2.be);
            st_d.s3.addr  = st_q.s2.addr;
            st_d.s3.be    = st_q.s2.be;
            st_d.s3.data  = wdata;
            // read output register
            st_d.out_valid = (st_q.s2.op == OP_READ);
            if (st_q.s2.op == OP_READ) st_d.out_data = fwd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata       = st_q.out_data;
    assign rdata_drive = st_q.out_valid && !out_en_n && !asleep;

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q)); // R7
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> $stable(st_q)); // R8
    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.s2.op == OP_WRITE && st_q.s2.be == '0) |=> !st_q.s3.valid); // R5
    AST_DESEL_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && load && !selected) |=> (st_q.s1.op == OP_NONE)); // R1
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !rdata_drive); // R8
endmodule

// File: tb/pipe_sram_tb.sv
`timescale 1ns/1ps
module pipe_sram_tb;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          hold = 0;
    logic          en0_n = 1, en1 = 0, en2_n = 1;
    logic          burst_next = 0;
    logic          write_n = 1;
    logic [NL-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          burst_linear = 0;
    logic          out_en_n = 0;
    logic          sleep = 0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    always #5 clk = ~clk;

    pipe_sram u_dut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
        .burst_next(burst_next), .write_n(write_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .wdata(wdata), .burst_linear(burst_linear), .out_en_n(out_en_n), .sleep(sleep),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    int total = 0;
    int bad = 0;
    string cur_tag = "R10";

    // reference model
    logic [DW-1:0] ref_mem [1<<AW];
    int            m_mode = 0;          // 0 none, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    int            p1_op = 0, p2_op = 0;
    logic [AW-1:0] p1_a = '0, p2_a = '0;
    logic [NL-1:0] p1_be = '0, p2_be = '0;
    bit            ev = 0;
    logic [DW-1:0] ed = '0;
    bit            zs1 = 0, zs2 = 0;
    bit            cur_sel = 0;

    task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] b, input int c, input bit lin);
        logic [AW-1:0] r;
        r = b;
        if (lin) r[1:0] = 2'((int'(b[1:0]) + c) % 4);
        else     r[1:0] = b[1:0] ^ 2'(c);
        return r;
    endfunction

    task automatic model_edge();
        bit sleeping;
        logic [AW-1:0] na;
        sleeping = zs2;
        zs2 = zs1;
        zs1 = sleep;
        if (!hold && !sleeping) begin
            ev = (p2_op == 1);
            if (p2_op == 1) ed = ref_mem[p2_a];
            if (p2_op == 2) begin
                for (int l = 0; l < NL; l++)
                    if (p2_be[l]) ref_mem[p2_a][l*LW +: LW] = wdata[l*LW +: LW];
            end
            p2_op = p1_op; p2_a = p1_a; p2_be = p1_be;
            if (!burst_next) begin
                m_mode = cur_sel ? (write_n ? 1 : 2) : 0;
                m_base = addr;
                m_cnt  = 0;
                na     = addr;
            end else begin
                if (m_mode != 0) m_cnt = (m_cnt + 1) % 4;
                na = burst_addr(m_base, m_cnt, burst_linear);
            end
            p1_op = m_mode; p1_a = na; p1_be = ~lane_wr_n;
        end
    endtask

    task automatic step(input bit h, input bit nxt, input bit wn, input bit sel,
                        input logic [NL-1:0] ben, input logic [AW-1:0] a, input bit oen);
        bit exp_drive;
        @(negedge clk);
        hold = h; burst_next = nxt; write_n = wn; lane_wr_n = ben; addr = a; out_en_n = oen;
        cur_sel = sel;
        if (sel) {en0_n, en1, en2_n} = 3'b010;
        else begin
            case ($urandom % 3)
                0: {en0_n, en1, en2_n} = 3'b110;
                1: {en0_n, en1, en2_n} = 3'b000;
                default: {en0_n, en1, en2_n} = 3'b011;
            endcase
        end
        wdata = DW'({$urandom, $urandom});
        @(posedge clk);
        model_edge();
        #1;
        exp_drive = ev && !out_en_n && !zs2;
        check("drive", DW'(rdata_drive), DW'(exp_drive));
        if (exp_drive) check("data", rdata, ed);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1, 0, 4'hF, '0, 0);
    endtask

    task automatic wr_load(input logic [AW-1:0] a, input logic [NL-1:0] ben);
        step(0, 0, 0, 1, ben, a, 0);
    endtask

    task automatic rd_load(input logic [AW-1:0] a, input bit oen);
        step(0, 0, 1, 1, 4'h0, a, oen);
    endtask

    task automatic cont(input logic [NL-1:0] ben, input bit oen);
        step(0, 1, $urandom % 2, $urandom % 2, ben, AW'($urandom), oen);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        cur_tag = "R10";
        check("reset drive", DW'(rdata_drive), '0);
        @(negedge clk);
        rst_n = 1;
        nop(3);

        // R3 fill every word with interleaved write bursts (R4)
        cur_tag = "R3";
        for (int b = 0; b < (1 << AW) / 4; b++) begin
            wr_load(AW'(b * 4 + (b % 4)), 4'h0);
            for (int k = 0; k < 3; k++) cont(4'h0, 0);
        end
        nop(3);
        // R2 read everything back
        cur_tag = "R2";
        for (int i = 0; i < (1 << AW); i++) rd_load(AW'(i), 0);
        nop(3);

        // R9 back-to-back alternation on the same word
        cur_tag = "R9";
        for (int i = 0; i < 6; i++) begin
            wr_load(AW'(3), 4'h0);
            rd_load(AW'(3), 0);
        end
        wr_load(AW'(9), 4'h0);
        wr_load(AW'(9), 4'h5);
        rd_load(AW'(9), 0);
        rd_load(AW'(9), 0);
        nop(3);

        // R3 partial lane writes
        cur_tag = "R3";
        wr_load(AW'(7), 4'b1011);
        nop(1);
        rd_load(AW'(7), 0);
        wr_load(AW'(7), 4'b0110);
        rd_load(AW'(7), 0);
        nop(3);

        // R5 aborted write burst then read
        cur_tag = "R5";
        wr_load(AW'(8), 4'hF);
        cont(4'hF, 0);
        cont(4'h0, 0);
        cont(4'hF, 0);
        rd_load(AW'(8), 0);
        for (int k = 0; k < 3; k++) cont(4'h0, 0);
        nop(3);

        // R4 linear and interleaved orders from every start position
        cur_tag = "R4";
        for (int lin = 0; lin < 2; lin++) begin
            burst_linear = lin[0];
            for (int s = 0; s < 4; s++) begin
                wr_load(AW'(20 + s), 4'h0);
                for (int k = 0; k < 3; k++) cont(4'h0, 0);
                rd_load(AW'(20 + ((s + 1) % 4)), 0);
                for (int k = 0; k < 3; k++) cont(4'h0, 0);
            end
            nop(3);
        end
        burst_linear = 0;

        // R6 dummy read advances the burst
        cur_tag = "R6";
        rd_load(AW'(4), 0);
        cont(4'h0, 0);
        step(0, 1, 1, 1, 4'h0, '0, 1);
        step(0, 1, 1, 1, 4'h0, '0, 1);
        step(0, 0, 1, 0, 4'hF, '0, 1);
        nop(2);
        nop(1);

        // R7 stall between address and data of a write
        cur_tag = "R7";
        wr_load(AW'(12), 4'h0);
        step(1, 0, 1, 1, 4'h0, AW'(40), 0);
        step(1, 1, 0, 0, 4'h0, AW'(41), 0);
        cont(4'h0, 0);
        rd_load(AW'(12), 0);
        step(1, 0, 0, 1, 4'h0, AW'(5), 0);
        cont(4'h0, 0);
        step(1, 1, 0, 1, 4'h0, '0, 0);
        nop(4);

        // R1 deselected loads write nothing and drive nothing
        cur_tag = "R1";
        step(0, 0, 0, 0, 4'h0, AW'(12), 0);
        cont(4'h0, 0);
        step(0, 0, 1, 0, 4'h0, AW'(12), 0);
        cont(4'h0, 0);
        rd_load(AW'(12), 0);
        rd_load(AW'(13), 0);
        nop(3);

        // R8 sleep: inputs ignored, contents retained
        cur_tag = "R8";
        @(negedge clk) sleep = 1;
        nop(2);
        for (int i = 0; i < 4; i++) wr_load(AW'(i), 4'h0);
        rd_load(AW'(2), 0);
        @(negedge clk) sleep = 0;
        nop(3);
        for (int i = 0; i < 4; i++) rd_load(AW'(i), 0);
        nop(3);

        // R9 random traffic
        cur_tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            bit h, nxt, wn, sel, oen;
            logic [NL-1:0] ben;
            h   = ($urandom % 10) == 0;
            nxt = ($urandom % 10) < 3;
            wn  = $urandom % 2;
            sel = ($urandom % 10) != 0;
            oen = ($urandom % 10) == 0;
            ben = NL'($urandom);
            if (($urandom % 4) == 0) ben = '0;
            if ((i % 500) == 0) burst_linear = ~burst_linear;
            step(h, nxt, wn, sel, ben, AW'($urandom % 16), oen);
        end
        nop(4);
        cur_tag = "R2";
        for (int i = 0; i < 16; i++) rd_load(AW'(i), 0);
        nop(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule